// File: doc/BRIEF.md
# Multicast Hash Filter

This block decides whether a received frame's destination address belongs to a subscribed multicast group. The six destination bytes are streamed in one per cycle. A reflected CRC-32 is formed over them and turned into a 6-bit index. That index selects one bit of a 64-bit table, which is kept as two 32-bit words. A frame is accepted when the selected table bit is set and the address has its group bit set.

Host software fills the table in one of two ways. It can write whole words through a simple register port and read them back. It can also present a complete 48-bit address on a helper port, and the block sets the matching table bit itself in one cycle. Reset clears the whole table.

The byte input and the result output are valid/ready streams. A result that is not taken stays on the output with its value unchanged. While such a result is pending, the whole lookup pipeline freezes and `in_ready` is low, so no new byte is accepted. When `res_ready` is high, the input is never back-pressured. The table ports are plain strobes with no handshake.

Top module: `mc_hash_filter`

## Requirements
- R1: After reset both table words read as zero, `res_valid` is low and `in_ready` is high.
- R2: A host write with `host_wr_en` high stores `host_wr_data` into the word chosen by `host_wr_sel` at the clock edge. `host_rd_data` shows the word chosen by `host_rd_sel` with no register delay.
- R3: The hash is formed as follows. Start from a CRC register of all ones. Fold in the address LSB-first with the reflected polynomial 0xEDB88320, byte 0 (`set_addr[7:0]` or the first streamed byte) first. Invert the result, then reverse it so that bit i moves to bit 31-i. In the hash, bit 31 picks table word 0 or 1 and bits 30:26 pick the bit within that word.
- R4: A cycle with `set_valid` high sets the table bit indexed by the hash of `set_addr`. Every other table bit keeps its value.
- R5: When a host write and a set hit the same word in the same cycle, that word becomes the written data with the hashed bit forced to 1.
- R6: `res_accept` is 1 only when the indexed table bit is 1 and bit 0 of the first address byte (the group bit) is 1. Otherwise it is 0.
- R7: If the sixth byte is accepted in cycle t and `res_ready` is high in cycle t+1, the result appears with `res_valid` high in cycle t+2.
- R8: While `res_valid` is high and `res_ready` is low, the result and its value hold and `in_ready` is low. Bytes offered in that time are not taken and do not disturb the next frame.
- R9: A lookup reads the table in the cycle after its sixth byte. A table write in that cycle, or in any later cycle, affects only later lookups.
- R10: The byte count restarts after each sixth byte, so frames may follow one another with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; clears the table |
| host_wr_en | input | 1 | Host word write strobe |
| host_wr_sel | input | 1 | Word written by the host |
| host_wr_data | input | 32 | Data for the host write |
| host_rd_sel | input | 1 | Word shown on the read port |
| host_rd_data | output | 32 | Contents of the selected word |
| set_valid | input | 1 | Set the table bit indexed by the hash of `set_addr` |
| set_addr | input | 48 | Address for the set helper, byte 0 in bits 7:0 |
| in_valid | input | 1 | Address byte valid |
| in_ready | output | 1 | Address byte accepted when high together with `in_valid` |
| in_byte | input | 8 | Address byte, byte 0 first |
| res_valid | output | 1 | Lookup result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_accept | output | 1 | 1 = accept frame, 0 = reject |

## Verification
The bound checker checks four behaviours on every cycle: a stalled result keeps its value, a result follows its sixth byte two cycles later when nothing stalls, no accept is given to an address whose group bit is clear, and a host write is visible on the read port. Whether the hash picks the correct word and bit, whether a set leaves the other bits alone, and how a write in the same cycle as a set or a lookup is ordered can only be shown by the bench's scenarios. The bench compares these against its own bit-serial CRC model.

// File: rtl/mchf_pkg.sv
package mchf_pkg;

  localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;
  localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;

  // Fold one byte into a reflected CRC, least significant bit first.
  function automatic logic [31:0] crc_byte(input logic [31:0] c_in, input logic [7:0] d);
    logic [31:0] c;
    c = c_in;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ d[i]) c = (c >> 1) ^ CRC_POLY;
      else             c = c >> 1;
    end
    return c;
  endfunction

  function automatic logic [31:0] bitrev32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[31-i] = v[i];
    return r;
  endfunction

endpackage

// File: rtl/mchf_crc_word.sv
module mchf_crc_word
  import mchf_pkg::*;
#(
  parameter int ADDR_BYTES = 6
) (
  input  logic [8*ADDR_BYTES-1:0] addr,
  output logic [31:0]             crc
);
  always_comb begin
    crc = CRC_INIT;
    for (int b = 0; b < ADDR_BYTES; b++) crc = crc_byte(crc, addr[8*b +: 8]);
  end
endmodule

// File: rtl/mchf_index.sv
module mchf_index
  import mchf_pkg::*;
#(
  parameter int WORDS  = 2,
  parameter int WORD_W = 32
) (
  input  logic [31:0]               crc,
  output logic [$clog2(WORDS)-1:0]  word_sel,
  output logic [$clog2(WORD_W)-1:0] bit_sel
);
  localparam int WSEL_W = $clog2(WORDS);
  localparam int BSEL_W = $clog2(WORD_W);
  localparam int LOW_TOP = 31 - WSEL_W - BSEL_W;

  logic [31:0] hash;
  logic        unused_hash_low;

  assign hash     = bitrev32(~crc);
  assign word_sel = hash[31 -: WSEL_W];
  assign bit_sel  = hash[31-WSEL_W -: BSEL_W];
  assign unused_hash_low = ^hash[LOW_TOP:0];
endmodule

// File: rtl/mchf_table.sv
module mchf_table #(
  parameter int WORDS  = 2,
  parameter int WORD_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [$clog2(WORDS)-1:0]  wr_sel,
  input  logic [WORD_W-1:0]         wr_data,
  input  logic                      set_en,
  input  logic [$clog2(WORDS)-1:0]  set_word,
  input  logic [$clog2(WORD_W)-1:0] set_bit,
  input  logic [$clog2(WORDS)-1:0]  rd_sel,
  output logic [WORD_W-1:0]         rd_data,
  input  logic [$clog2(WORDS)-1:0]  lk_word,
  input  logic [$clog2(WORD_W)-1:0] lk_bit,
  output logic                      lk_hit
);
  localparam int WSEL_W = $clog2(WORDS);

  logic [WORD_W-1:0] words [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [WORD_W-1:0] nxt;
    always_comb begin
      nxt = words[w];
      if (wr_en && wr_sel == WSEL_W'(w)) nxt = wr_data;
      if (set_en && set_word == WSEL_W'(w)) nxt[set_bit] = 1'b1;
    end
    always_ff @(posedge clk) begin
      if (!rst_n) words[w] <= '0;
      else        words[w] <= nxt;
    end
  end

  assign rd_data = words[rd_sel];
  assign lk_hit  = words[lk_word][lk_bit];
endmodule

// File: rtl/mc_hash_filter.sv
module mc_hash_filter
  import mchf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int WORDS      = 2,
  parameter int WORD_W     = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        host_wr_en,
  input  logic [$clog2(WORDS)-1:0]    host_wr_sel,
  input  logic [WORD_W-1:0]           host_wr_data,
  input  logic [$clog2(WORDS)-1:0]    host_rd_sel,
  output logic [WORD_W-1:0]           host_rd_data,
  input  logic                        set_valid,
  input  logic [8*ADDR_BYTES-1:0]     set_addr,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [7:0]                  in_byte,
  output logic                        res_valid,
  input  logic                        res_ready,
  output logic                        res_accept
);
  localparam int WSEL_W = $clog2(WORDS);
  localparam int BSEL_W = $clog2(WORD_W);
  localparam int CNT_W  = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

  // set helper path: full-address hash in one cycle
  logic [31:0]       set_crc;
  logic [WSEL_W-1:0] set_word;
  logic [BSEL_W-1:0] set_bit;

  mchf_crc_word #(.ADDR_BYTES(ADDR_BYTES)) u_set_crc (
    .addr (set_addr),
    .crc  (set_crc)
  );

  mchf_index #(.WORDS(WORDS), .WORD_W(WORD_W)) u_set_idx (
    .crc      (set_crc),
    .word_sel (set_word),
    .bit_sel  (set_bit)
  );

  // streaming lookup path
  logic              en, fire, last;
  logic [CNT_W-1:0]  cnt_q;
  logic [31:0]       crc_q, crc_nxt, fin_crc_q;
  logic              grp_q, grp_nxt;
  logic              fin_vld_q, fin_grp_q;
  logic              res_vld_q, res_acc_q;
  logic [WSEL_W-1:0] lk_word;
  logic [BSEL_W-1:0] lk_bit;
  logic              lk_hit;

  assign en   = !(res_vld_q && !res_ready);
  assign fire = in_valid && en;
  assign last = (cnt_q == CNT_W'(ADDR_BYTES - 1));

  always_comb begin
    crc_nxt = crc_byte((cnt_q == '0) ? CRC_INIT : crc_q, in_byte);
    grp_nxt = (cnt_q == '0) ? in_byte[0] : grp_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      crc_q <= CRC_INIT;
      grp_q <= 1'b0;
    end else if (fire) begin
      cnt_q <= last ? '0 : cnt_q + 1'b1;
      crc_q <= crc_nxt;
      grp_q <= grp_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fin_vld_q <= 1'b0;
      fin_crc_q <= '0;
      fin_grp_q <= 1'b0;
      res_vld_q <= 1'b0;
      res_acc_q <= 1'b0;
    end else if (en) begin
      fin_vld_q <= fire && last;
      if (fire && last) begin
        fin_crc_q <= crc_nxt;
        fin_grp_q <= grp_nxt;
      end
      res_vld_q <= fin_vld_q;
      res_acc_q <= fin_vld_q && lk_hit && fin_grp_q;
    end
  end

  mchf_index #(.WORDS(WORDS), .WORD_W(WORD_W)) u_lk_idx (
    .crc      (fin_crc_q),
    .word_sel (lk_word),
    .bit_sel  (lk_bit)
  );

  mchf_table #(.WORDS(WORDS), .WORD_W(WORD_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (host_wr_en),
    .wr_sel   (host_wr_sel),
    .wr_data  (host_wr_data),
    .set_en   (set_valid),
    .set_word (set_word),
    .set_bit  (set_bit),
    .rd_sel   (host_rd_sel),
    .rd_data  (host_rd_data),
    .lk_word  (lk_word),
    .lk_bit   (lk_bit),
    .lk_hit   (lk_hit)
  );

  assign in_ready   = en;
  assign res_valid  = res_vld_q;
  assign res_accept = res_acc_q;
endmodule

// File: rtl/mchf_checker.sv
module mchf_checker #(
  parameter int ADDR_BYTES = 6,
  parameter int WORDS      = 2,
  parameter int WORD_W     = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     host_wr_en,
  input logic [$clog2(WORDS)-1:0] host_wr_sel,
  input logic [WORD_W-1:0]        host_wr_data,
  input logic [$clog2(WORDS)-1:0] host_rd_sel,
  input logic [WORD_W-1:0]        host_rd_data,
  input logic                     set_valid,
  input logic                     in_valid,
  input logic                     in_ready,
  input logic                     grp_bit,
  input logic                     res_valid,
  input logic                     res_ready,
  input logic                     res_accept
);
  localparam int CNT_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

  logic [CNT_W-1:0] cnt;
  logic             grp_cur, grp_last, fire6_q;
  logic             fire, fire6;

  assign fire  = in_valid && in_ready;
  assign fire6 = fire && (cnt == CNT_W'(ADDR_BYTES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      grp_cur  <= 1'b0;
      grp_last <= 1'b0;
      fire6_q  <= 1'b0;
    end else begin
      fire6_q <= fire6;
      if (fire) begin
        cnt <= fire6 ? '0 : cnt + 1'b1;
        if (cnt == '0) grp_cur <= grp_bit;
        if (fire6) grp_last <= (cnt == '0) ? grp_bit : grp_cur;
      end
    end
  end

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_accept)); // R8

  AST_TWO_CYCLE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    fire6_q && !(res_valid && !res_ready) |=> res_valid); // R7

  AST_GROUP_NEEDED: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_accept |-> grp_last); // R6

  AST_WRITE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr_en && !set_valid |=>
      (host_rd_sel != $past(host_wr_sel)) || (host_rd_data == $past(host_wr_data))); // R2
endmodule

bind mc_hash_filter mchf_checker #(
  .ADDR_BYTES (ADDR_BYTES),
  .WORDS      (WORDS),
  .WORD_W     (WORD_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .host_wr_en   (host_wr_en),
  .host_wr_sel  (host_wr_sel),
  .host_wr_data (host_wr_data),
  .host_rd_sel  (host_rd_sel),
  .host_rd_data (host_rd_data),
  .set_valid    (set_valid),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .grp_bit      (in_byte[0]),
  .res_valid    (res_valid),
  .res_ready    (res_ready),
  .res_accept   (res_accept)
);

// File: tb/mc_hash_filter_tb_top.sv
module mc_hash_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr_en = 1'b0;
  logic        host_wr_sel = 1'b0;
  logic [31:0] host_wr_data = '0;
  logic        host_rd_sel = 1'b0;
  logic [31:0] host_rd_data;
  logic        set_valid = 1'b0;
  logic [47:0] set_addr = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_byte = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic        res_accept;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #10 clk = ~clk;

  mc_hash_filter dut_i (
    .clk(clk), .rst_n(rst_n),
    .host_wr_en(host_wr_en), .host_wr_sel(host_wr_sel), .host_wr_data(host_wr_data),
    .host_rd_sel(host_rd_sel), .host_rd_data(host_rd_data),
    .set_valid(set_valid), .set_addr(set_addr),
    .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
    .res_valid(res_valid), .res_ready(res_ready), .res_accept(res_accept)
  );

  // bit-serial reference hash over the 48 address bits
  function automatic logic [31:0] ref_hash(input logic [47:0] a);
    logic [31:0] r;
    logic [31:0] h;
    logic        fb;
    r = 32'hFFFF_FFFF;
    for (int i = 0; i < 48; i++) begin
      fb = r[0] ^ a[i];
      r  = {1'b0, r[31:1]};
      if (fb) r = r ^ 32'hEDB8_8320;
    end
    r = ~r;
    for (int i = 0; i < 32; i++) h[31-i] = r[i];
    return h;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle reference model
  logic [31:0] m_tbl [2];
  bit          m_rv, m_ra, m_fv, m_fgrp;
  logic [5:0]  m_fidx;
  logic [7:0]  m_q [$];

  always @(posedge clk) begin
    logic [31:0] h;
    logic [47:0] a;
    bit          stall;
    if (!rst_n) begin
      m_tbl[0] = '0; m_tbl[1] = '0;
      m_rv = 0; m_ra = 0; m_fv = 0; m_fgrp = 0; m_fidx = '0;
      m_q.delete();
    end else begin
      stall = m_rv && !res_ready;
      if (!stall) begin
        m_ra = m_fv && m_fgrp && m_tbl[m_fidx[5]][m_fidx[4:0]];
        m_rv = m_fv;
        m_fv = 0;
        if (in_valid) begin
          m_q.push_back(in_byte);
          if (m_q.size() == 6) begin
            for (int k = 0; k < 6; k++) a[8*k +: 8] = m_q[k];
            h = ref_hash(a);
            m_fidx = h[31:26];
            m_fgrp = a[0];
            m_fv = 1;
            m_q.delete();
          end
        end
      end
      if (host_wr_en) m_tbl[host_wr_sel] = host_wr_data;
      if (set_valid) begin
        h = ref_hash(set_addr);
        m_tbl[h[31]][h[30:26]] = 1'b1;
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk(in_ready == !(m_rv && !res_ready), "R8 in_ready", 32'(in_ready), 32'(!(m_rv && !res_ready)));
      chk(res_valid == m_rv, "R7 res_valid", 32'(res_valid), 32'(m_rv));
      if (m_rv) chk(res_accept == m_ra, "R6 res_accept", 32'(res_accept), 32'(m_ra));
      chk(host_rd_data == m_tbl[host_rd_sel], "R2 host_rd_data", host_rd_data, m_tbl[host_rd_sel]);
    end
  end

  task automatic quiet();
    @(negedge clk);
    in_valid = 0; host_wr_en = 0; set_valid = 0;
  endtask

  task automatic hw_write(input bit sel, input logic [31:0] d);
    @(negedge clk);
    in_valid = 0; set_valid = 0;
    host_wr_en = 1; host_wr_sel = sel; host_wr_data = d;
  endtask

  task automatic send_frame(input logic [47:0] a);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      host_wr_en = 0; set_valid = 0;
      in_valid = 1; in_byte = a[8*k +: 8];
    end
  endtask

  task automatic clear_table();
    hw_write(0, 32'h0);
    hw_write(1, 32'h0);
    quiet();
  endtask

  initial begin
    logic [47:0] addr_a, addr_b, addr_a2, addr_c;
    logic [31:0] ha, hb, ha2, hc, expw;
    addr_a  = 48'h0000_5E00_0001;
    addr_b  = addr_a & ~48'h1;
    addr_a2 = addr_a ^ 48'h0000_0000_0100;
    addr_c  = 48'h0000_0000_0033;
    ha = ref_hash(addr_a); hb = ref_hash(addr_b);
    ha2 = ref_hash(addr_a2); hc = ref_hash(addr_c);

    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    @(negedge clk); #3;
    host_rd_sel = 0; #1;
    chk(host_rd_data == 0, "R1 word0", host_rd_data, 0);
    host_rd_sel = 1; #1;
    chk(host_rd_data == 0, "R1 word1", host_rd_data, 0);
    chk(in_ready == 1 && res_valid == 0, "R1 handshake", {30'b0, in_ready, res_valid}, 32'h2);

    // R2: host write and read back
    hw_write(0, 32'hA5A5_0F0F);
    hw_write(1, 32'h1234_8001);
    quiet(); #3;
    host_rd_sel = 0; #1;
    chk(host_rd_data == 32'hA5A5_0F0F, "R2 word0", host_rd_data, 32'hA5A5_0F0F);
    host_rd_sel = 1; #1;
    chk(host_rd_data == 32'h1234_8001, "R2 word1", host_rd_data, 32'h1234_8001);

    // R3, R7: program the hashed bit by hand, then look up
    clear_table();
    hw_write(ha[31], 32'h1 << ha[30:26]);
    send_frame(addr_a);
    quiet(); #3;
    chk(res_valid == 0, "R7 not yet", 32'(res_valid), 0);
    @(negedge clk); #3;
    chk(res_valid == 1, "R7 two cycles", 32'(res_valid), 1);
    chk(res_accept == 1, "R3 hashed bit hit", 32'(res_accept), 1);

    // R3: address with different index is rejected
    if (ha2[31:26] != ha[31:26]) begin
      send_frame(addr_a2);
      quiet(); @(negedge clk); #3;
      chk(res_valid && !res_accept, "R3 other index", 32'(res_accept), 0);
    end

    // R6: bit set but group bit clear
    clear_table();
    hw_write(hb[31], 32'h1 << hb[30:26]);
    send_frame(addr_b);
    quiet(); @(negedge clk); #3;
    chk(res_valid && !res_accept, "R6 group clear", 32'(res_accept), 0);

    // R4: set helper
    clear_table();
    @(negedge clk); set_valid = 1; set_addr = addr_a;
    quiet(); #3;
    host_rd_sel = ha[31]; #1;
    chk(host_rd_data == (32'h1 << ha[30:26]), "R4 single bit", host_rd_data, 32'h1 << ha[30:26]);
    host_rd_sel = ~ha[31]; #1;
    chk(host_rd_data == 0, "R4 other word", host_rd_data, 0);
    @(negedge clk); set_valid = 1; set_addr = addr_c;
    quiet(); #3;
    host_rd_sel = hc[31]; #1;
    expw = (32'h1 << hc[30:26]) | ((hc[31] == ha[31]) ? (32'h1 << ha[30:26]) : 32'h0);
    chk(host_rd_data == expw, "R4 keeps bits", host_rd_data, expw);

    // R5: write and set on the same word together
    clear_table();
    @(negedge clk);
    host_wr_en = 1; host_wr_sel = ha[31]; host_wr_data = 32'h0000_F000;
    set_valid = 1; set_addr = addr_a;
    quiet(); #3;
    host_rd_sel = ha[31]; #1;
    expw = 32'h0000_F000 | (32'h1 << ha[30:26]);
    chk(host_rd_data == expw, "R5 write plus set", host_rd_data, expw);

    // R9: clearing the table in the lookup cycle does not change that result
    clear_table();
    hw_write(ha[31], 32'h1 << ha[30:26]);
    send_frame(addr_a);
    @(negedge clk);
    in_valid = 0; host_wr_en = 1; host_wr_sel = ha[31]; host_wr_data = 32'h0;
    quiet(); #3;
    chk(res_valid && res_accept, "R9 old table used", 32'(res_accept), 1);
    send_frame(addr_a);
    quiet(); @(negedge clk); #3;
    chk(res_valid && !res_accept, "R9 later lookup", 32'(res_accept), 0);

    // R8: stalled result
    hw_write(ha[31], 32'h1 << ha[30:26]);
    quiet();
    res_ready = 0;
    send_frame(addr_a);
    quiet(); @(negedge clk); #3;
    chk(res_valid == 1, "R8 result shown", 32'(res_valid), 1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      in_valid = 1; in_byte = 8'hFF; #3;
      chk(in_ready == 0, "R8 input blocked", 32'(in_ready), 0);
      chk(res_valid && res_accept, "R8 result held", {30'b0, res_valid, res_accept}, 32'h3);
    end
    @(negedge clk);
    in_valid = 0; res_ready = 1;
    @(negedge clk); #3;
    chk(res_valid == 0, "R8 taken", 32'(res_valid), 0);
    send_frame(addr_a);
    quiet(); @(negedge clk); #3;
    chk(res_valid && res_accept, "R8 blocked bytes dropped", 32'(res_accept), 1);

    // R10: back-to-back frames
    send_frame(addr_a);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      in_valid = 1; in_byte = addr_a2[8*k +: 8];
      if (k == 1) begin
        #3;
        chk(res_valid && res_accept, "R10 first frame", {30'b0, res_valid, res_accept}, 32'h3);
      end
    end
    quiet(); @(negedge clk); #3;
    expw = (ha2[31:26] == ha[31:26]) ? 32'h1 : 32'h0;
    chk(res_valid && (res_accept == expw[0]), "R10 second frame", 32'(res_accept), expw);

    repeat (3) quiet();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule